// File: doc/BRIEF.md
# Serial Link Transmit Scheduler

This block decides, on every clock, what a single 2-byte lane of a lightweight serial link transmits. It merges four sources: clock-compensation sequences, short priority messages with a length tag, idle periods requested by the link partner, and framed user data. When none of them has anything to send, it fills the cycle with idle characters. Its output is a 16-bit symbol word with one control flag per byte, ready for an 8B/10B encoder. `tx_sym[15:8]` is the first byte on the line, and `tx_ctl[1]` flags that byte.

User frames arrive on a valid/ready port. The block adds a start word before the first data word and an end word after the last one. When a frame ends on an odd byte, the block pads it. A priority message is requested with `msg_req` and is granted with a same-cycle `msg_ack`. Its payload words are then taken from the same data port, with `s_ready` low and `msg_pull` high. A partner pause is a one-cycle `pause_req` that carries a 4-bit idle count. The parameter `DRAIN_FRAME` decides whether the pause cuts into a frame at once or waits until the frame is closed.

Top module: `tx_link_sched`

## Requirements
- R1: After reset the lane sends the idle word 0xBCBC with `tx_ctl`=11, and `s_ready`, `msg_ack` and `msg_pull` are low.
- R2: In any cycle with nothing to send, the output is the idle word 0xBCBC with `tx_ctl`=11.
- R3: A frame starts with one start word 0xFBFB (`tx_ctl`=11, `s_ready` low). It continues with one data word per accepted beat (`tx_ctl`=00) and ends with one end word 0xFDFD (`tx_ctl`=11) in the cycle after the beat with `s_last`. Inside a frame, `s_ready` is high whenever no higher source is active.
- R4: A last beat that has `s_odd` set sends its upper byte as data and replaces its lower byte with the pad character 0x9C, with `tx_ctl`=01.
- R5: A high `cc_req` between sequences starts a sequence of 4 cycles of 0xF7F7 (`tx_ctl`=11). During the sequence, `s_ready` and `msg_ack` stay low and `cc_req` is not sampled. If `cc_req` is still high when the sequence ends, a new sequence starts.
- R6: While `cc_warn` is high, no new priority message is acknowledged.
- R7: `msg_ack` rises in the same cycle as a pending `msg_req` when no sequence is running. That cycle sends the header {0x5C, size} with `tx_ctl`=10, and `s_ready` is low in the following cycle.
- R8: A size code N is followed by N+1 payload cycles. Each payload cycle sends `s_data` unchanged with `tx_ctl`=00, `msg_pull` high and `s_ready` low. A clock-compensation sequence that falls inside the message suspends the payload, which then resumes.
- R9: With `DRAIN_FRAME`=0, a nonzero pause count C makes the lane send exactly C idle cycles, starting in the cycle after `pause_req`, even in the middle of a frame.
- R10: With `DRAIN_FRAME`=1, the pause idles begin only once the current frame's end word has been sent.
- R11: A pause count of 0 holds the lane idle until a pause request with a nonzero count arrives. That later request then sets the remaining count.
- R12: The order of precedence is clock compensation, then message payload, then a new message, then the pause, then frame data. A new message therefore goes out before a pending pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 16 | Frame data word, or message payload while `msg_pull` is high |
| s_valid | input | 1 | Frame data word valid |
| s_last | input | 1 | Beat is the last one of its frame |
| s_odd | input | 1 | The last beat carries only its upper byte |
| s_ready | output | 1 | A frame beat is taken this cycle if it is valid |
| cc_req | input | 1 | Clock-compensation request |
| cc_warn | input | 1 | Compensation is imminent; blocks new messages |
| msg_req | input | 1 | Priority message request |
| msg_size | input | 3 | Message size code N; payload is (N+1)*2 bytes |
| msg_ack | output | 1 | Message granted; header sent this cycle |
| msg_pull | output | 1 | `s_data` is consumed as message payload this cycle |
| pause_req | input | 1 | One-cycle pause request from the partner |
| pause_cnt | input | 4 | Idle cycles to insert; 0 means unbounded |
| tx_sym | output | 16 | Lane symbol word, upper byte first |
| tx_ctl | output | 2 | Control-character flag for each byte |

## Verification
The in-line assertions check, on every cycle, the local rules of precedence. A compensation cycle never carries ready or an acknowledge, a warning never coincides with an acknowledge, ready is low after a grant and during payload, and in immediate mode a pending pause with nothing higher gives an idle word. Only the bench's scenarios can show the properties that need counting or ordering over many cycles. These are the exact sequence length, the payload length for a given size code, the number of pause idles, the unbounded pause and its release, the deferral in drain mode, and the framing and padding of whole frames. The bench compares both the immediate-mode and the drain-mode instance against a behavioural model on every clock.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
    localparam int LANE_B = 2;
    localparam int LANE_W = 8 * LANE_B;

    localparam logic [7:0] K_IDLE = 8'hBC;
    localparam logic [7:0] K_SOF  = 8'hFB;
    localparam logic [7:0] K_EOF  = 8'hFD;
    localparam logic [7:0] K_PAD  = 8'h9C;
    localparam logic [7:0] K_CC   = 8'hF7;
    localparam logic [7:0] K_MSG  = 8'h5C;

    typedef enum logic [2:0] {
        SRC_IDLE, SRC_CC, SRC_HDR, SRC_PAY, SRC_PAUSE, SRC_EOF, SRC_DATA, SRC_SOF
    } src_e;

    typedef struct packed {
        logic [LANE_W-1:0] sym;
        logic [LANE_B-1:0] ctl;
    } lane_word_t;

    function automatic lane_word_t k_pair(input logic [7:0] k);
        lane_word_t w;
        w.sym = {k, k};
        w.ctl = 2'b11;
        return w;
    endfunction
endpackage

// File: rtl/tx_cc_timer.sv
module tx_cc_timer #(
    parameter int CC_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cc_req,
    output logic cc_emit
);
    localparam int W = (CC_LEN > 1) ? $clog2(CC_LEN) : 1;

    logic [W-1:0] left_q;

    assign cc_emit = (left_q != '0) || cc_req;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
        else if (cc_req)
            left_q <= W'(CC_LEN - 1);
    end
endmodule

// File: rtl/tx_msg_ctl.sv
module tx_msg_ctl #(
    parameter int SZW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           msg_req,
    input  logic [SZW-1:0] msg_size,
    input  logic           cc_warn,
    input  logic           cc_emit,
    output logic           msg_ack,
    output logic           pay_now
);
    localparam int CW = SZW + 1;

    logic [CW-1:0] left_q;

    assign pay_now = (left_q != '0) && !cc_emit;
    assign msg_ack = msg_req && (left_q == '0) && !cc_emit && !cc_warn;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (msg_ack)
            left_q <= CW'(msg_size) + CW'(1);
        else if (pay_now)
            left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/tx_pause_ctl.sv
module tx_pause_ctl #(
    parameter int CNTW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pause_req,
    input  logic [CNTW-1:0] pause_cnt,
    input  logic            take,
    output logic            pending
);
    logic [CNTW-1:0] left_q;
    logic            inf_q;

    assign pending = inf_q || (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            inf_q  <= 1'b0;
        end else if (pause_req) begin
            inf_q  <= (pause_cnt == '0);
            left_q <= pause_cnt;
        end else if (take && !inf_q && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/tx_link_sched.sv
module tx_link_sched
    import tx_sched_pkg::*;
#(
    parameter int SZW         = 3,
    parameter int CNTW        = 4,
    parameter int CC_LEN      = 4,
    parameter bit DRAIN_FRAME = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              s_odd,
    output logic              s_ready,
    input  logic              cc_req,
    input  logic              cc_warn,
    input  logic              msg_req,
    input  logic [SZW-1:0]    msg_size,
    output logic              msg_ack,
    output logic              msg_pull,
    input  logic              pause_req,
    input  logic [CNTW-1:0]   pause_cnt,
    output logic [LANE_W-1:0] tx_sym,
    output logic [LANE_B-1:0] tx_ctl
);
    logic       cc_emit, pay_now, pause_pending, pause_ok, take;
    logic       frame_q, eof_q;
    src_e       src;
    lane_word_t word;

    tx_cc_timer #(.CC_LEN(CC_LEN)) u_cc (
        .clk(clk), .rst(rst), .cc_req(cc_req), .cc_emit(cc_emit)
    );

    tx_msg_ctl #(.SZW(SZW)) u_msg (
        .clk(clk), .rst(rst), .msg_req(msg_req), .msg_size(msg_size),
        .cc_warn(cc_warn), .cc_emit(cc_emit), .msg_ack(msg_ack), .pay_now(pay_now)
    );

    tx_pause_ctl #(.CNTW(CNTW)) u_pause (
        .clk(clk), .rst(rst), .pause_req(pause_req), .pause_cnt(pause_cnt),
        .take(take), .pending(pause_pending)
    );

    generate
        if (DRAIN_FRAME) begin : g_drain
            assign pause_ok = !frame_q && !eof_q;
        end else begin : g_now
            assign pause_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        src     = SRC_IDLE;
        s_ready = 1'b0;
        take    = 1'b0;
        if (cc_emit)
            src = SRC_CC;
        else if (pay_now)
            src = SRC_PAY;
        else if (msg_ack)
            src = SRC_HDR;
        else if (pause_pending && pause_ok) begin
            src  = SRC_PAUSE;
            take = 1'b1;
        end else if (eof_q)
            src = SRC_EOF;
        else if (frame_q) begin
            s_ready = 1'b1;
            if (s_valid)
                src = SRC_DATA;
        end else if (s_valid)
            src = SRC_SOF;
    end

    always_comb begin
        word = k_pair(K_IDLE);
        unique case (src)
            SRC_CC:  word = k_pair(K_CC);
            SRC_SOF: word = k_pair(K_SOF);
            SRC_EOF: word = k_pair(K_EOF);
            SRC_PAY: begin
                word.sym = s_data;
                word.ctl = 2'b00;
            end
            SRC_HDR: begin
                word.sym = {K_MSG, {(8-SZW){1'b0}}, msg_size};
                word.ctl = 2'b10;
            end
            SRC_DATA: begin
                if (s_last && s_odd) begin
                    word.sym = {s_data[15:8], K_PAD};
                    word.ctl = 2'b01;
                end else begin
                    word.sym = s_data;
                    word.ctl = 2'b00;
                end
            end
            default: word = k_pair(K_IDLE);
        endcase
    end

    assign tx_sym   = word.sym;
    assign tx_ctl   = word.ctl;
    assign msg_pull = pay_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b0;
            eof_q   <= 1'b0;
        end else begin
            case (src)
                SRC_SOF:  frame_q <= 1'b1;
                SRC_EOF:  eof_q   <= 1'b0;
                SRC_DATA: if (s_last) begin
                    frame_q <= 1'b0;
                    eof_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R5: a compensation cycle carries the compensation word and grants nothing
    assert_cc_excl_R5: assert property (@(posedge clk) disable iff (rst)
        cc_emit |-> (tx_sym == {K_CC, K_CC} && !s_ready && !msg_ack));

    // R6: no grant while the warning is up
    assert_warn_block_R6: assert property (@(posedge clk) disable iff (rst)
        cc_warn |-> !msg_ack);

    // R7: user data is not accepted in the cycle after a grant
    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (rst)
        msg_ack |=> !s_ready);

    // R8: payload cycles take no frame data and carry no control flags
    assert_payload_R8: assert property (@(posedge clk) disable iff (rst)
        msg_pull |-> (!s_ready && tx_ctl == 2'b00 && tx_sym == s_data));

    generate
        if (!DRAIN_FRAME) begin : g_chk_now
            // R9: a pending pause with nothing above it forces an idle word
            assert_pause_idle_R9: assert property (@(posedge clk) disable iff (rst)
                (pause_pending && !cc_emit && !msg_pull && !msg_ack)
                    |-> (tx_sym == {K_IDLE, K_IDLE} && !s_ready));
        end else begin : g_chk_drain
            // R10: while a frame is open in drain mode, a pause never lowers ready
            assert_pause_defer_R10: assert property (@(posedge clk) disable iff (rst)
                (frame_q && !eof_q && !cc_emit && !msg_pull && !msg_ack) |-> s_ready);
        end
    endgenerate
endmodule

// File: tb/tx_link_sched_bench.sv
module tx_link_sched_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic [15:0] sd [2];
    logic        sv [2];
    logic        sl [2];
    logic        so [2];
    logic        cc_req, cc_warn, msg_req, pause_req;
    logic [2:0]  msg_size;
    logic [3:0]  pause_cnt;
    logic [15:0] sym [2];
    logic [1:0]  ctl [2];
    logic        rdy [2];
    logic        ack [2];
    logic        pull [2];

    tx_link_sched #(.DRAIN_FRAME(1'b0)) u_tx_link_sched (
        .clk(clk), .rst(rst), .s_data(sd[0]), .s_valid(sv[0]), .s_last(sl[0]), .s_odd(so[0]),
        .s_ready(rdy[0]), .cc_req(cc_req), .cc_warn(cc_warn), .msg_req(msg_req),
        .msg_size(msg_size), .msg_ack(ack[0]), .msg_pull(pull[0]), .pause_req(pause_req),
        .pause_cnt(pause_cnt), .tx_sym(sym[0]), .tx_ctl(ctl[0]));

    tx_link_sched #(.DRAIN_FRAME(1'b1)) u_tx_link_sched_drain (
        .clk(clk), .rst(rst), .s_data(sd[1]), .s_valid(sv[1]), .s_last(sl[1]), .s_odd(so[1]),
        .s_ready(rdy[1]), .cc_req(cc_req), .cc_warn(cc_warn), .msg_req(msg_req),
        .msg_size(msg_size), .msg_ack(ack[1]), .msg_pull(pull[1]), .pause_req(pause_req),
        .pause_cnt(pause_cnt), .tx_sym(sym[1]), .tx_ctl(ctl[1]));

    // staged stimulus, applied at the falling edge
    logic       st_cc, st_warn, st_msg, st_preq;
    logic [2:0] st_size;
    logic [3:0] st_pcnt;

    // behavioural model state
    int cc_left [2];
    int ml [2];
    int pl [2];
    bit pinf [2];
    bit infr [2];
    bit eofp [2];
    logic [17:0] fq0 [$];
    logic [17:0] fq1 [$];
    logic [15:0] e_sym [2];
    logic [1:0]  e_ctl [2];
    bit e_rdy [2];
    bit e_ack [2];
    bit e_pull [2];
    logic [15:0] pword;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req;

    task automatic push_frame(input int n, input bit odd, input logic [7:0] tag);
        for (int i = 0; i < n; i++) begin
            logic [17:0] w;
            w = {(i == n - 1), (odd && i == n - 1), tag, 8'(i)};
            fq0.push_back(w);
            fq1.push_back(w);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cc_req = st_cc; cc_warn = st_warn; msg_req = st_msg; msg_size = st_size;
        pause_req = st_preq; pause_cnt = st_pcnt;
        st_preq = 1'b0;
        for (int m = 0; m < 2; m++) begin
            logic [17:0] h;
            bit v, cc, pay, a, pp, pau;
            v = (m == 0) ? (fq0.size() != 0) : (fq1.size() != 0);
            h = v ? ((m == 0) ? fq0[0] : fq1[0]) : 18'h0;
            cc = (cc_left[m] != 0) || cc_req;
            pay = !cc && ml[m] != 0;
            a = !cc && !pay && msg_req && !cc_warn;
            pp = pinf[m] || pl[m] != 0;
            pau = !cc && !pay && !a && pp && (m == 0 || (!infr[m] && !eofp[m]));
            sv[m] = v; sl[m] = h[17]; so[m] = h[16];
            sd[m] = pay ? pword : h[15:0];
            e_rdy[m] = 0; e_ack[m] = a; e_pull[m] = pay;
            e_sym[m] = 16'hBCBC; e_ctl[m] = 2'b11;
            if (cc) e_sym[m] = 16'hF7F7;
            else if (pay) begin e_sym[m] = pword; e_ctl[m] = 2'b00; end
            else if (a) begin e_sym[m] = {8'h5C, 5'b0, msg_size}; e_ctl[m] = 2'b10; end
            else if (pau) e_sym[m] = 16'hBCBC;
            else if (eofp[m]) begin e_sym[m] = 16'hFDFD; eofp[m] = 0; end
            else if (infr[m]) begin
                e_rdy[m] = 1;
                if (v) begin
                    if (h[17] && h[16]) begin e_sym[m] = {h[15:8], 8'h9C}; e_ctl[m] = 2'b01; end
                    else begin e_sym[m] = h[15:0]; e_ctl[m] = 2'b00; end
                    if (h[17]) begin infr[m] = 0; eofp[m] = 1; end
                    if (m == 0) void'(fq0.pop_front()); else void'(fq1.pop_front());
                end
            end else if (v) begin e_sym[m] = 16'hFBFB; infr[m] = 1; end
            if (cc_left[m] != 0) cc_left[m]--; else if (cc_req) cc_left[m] = 3;
            if (a) ml[m] = int'(msg_size) + 1; else if (pay) ml[m]--;
            if (pause_req) begin
                pinf[m] = (pause_cnt == 0); pl[m] = int'(pause_cnt);
            end else if (pau && !pinf[m] && pl[m] != 0) pl[m]--;
        end
        #1;
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (sym[m] !== e_sym[m] || ctl[m] !== e_ctl[m] || rdy[m] !== e_rdy[m] ||
                ack[m] !== e_ack[m] || pull[m] !== e_pull[m]) begin
                fails++;
                $display("FAIL %s inst%0d: sym=%h ctl=%b rdy=%b ack=%b pull=%b expected sym=%h ctl=%b rdy=%b ack=%b pull=%b",
                         cur_req, m, sym[m], ctl[m], rdy[m], ack[m], pull[m],
                         e_sym[m], e_ctl[m], e_rdy[m], e_ack[m], e_pull[m]);
            end
        end
        if (e_ack[0]) st_msg = 1'b0;
        pword = pword + 16'h0101;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        st_cc = 0; st_warn = 0; st_msg = 0; st_preq = 0; st_size = 0; st_pcnt = 0;
        cc_req = 0; cc_warn = 0; msg_req = 0; pause_req = 0; msg_size = 0; pause_cnt = 0;
        pword = 16'hA000;
        for (int m = 0; m < 2; m++) begin
            sd[m] = 0; sv[m] = 0; sl[m] = 0; so[m] = 0;
            cc_left[m] = 0; ml[m] = 0; pl[m] = 0; pinf[m] = 0; infr[m] = 0; eofp[m] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1 reset"; run(2);
        cur_req = "R2 idle fill"; run(3);
        cur_req = "R3 even frame"; push_frame(3, 0, 8'h11); run(8);
        cur_req = "R4 odd pad"; push_frame(2, 1, 8'h22); run(6);
        cur_req = "R5 compensation";
        push_frame(5, 0, 8'h33); run(2);
        st_cc = 1; run(1); st_cc = 0; run(8);
        st_cc = 1; run(9); st_cc = 0; run(4);
        cur_req = "R7 R8 message"; push_frame(4, 0, 8'h44); run(2);
        st_msg = 1; st_size = 3'd2; run(9);
        cur_req = "R8 cc inside payload"; st_msg = 1; st_size = 3'd3; run(2);
        st_cc = 1; run(1); st_cc = 0; run(8);
        cur_req = "R6 warning"; st_warn = 1; st_msg = 1; st_size = 3'd0; run(4);
        st_warn = 0; run(4);
        cur_req = "R9 R10 counted pause"; push_frame(6, 0, 8'h55); run(2);
        st_preq = 1; st_pcnt = 4'd3; run(14);
        cur_req = "R11 unbounded pause"; push_frame(3, 1, 8'h66);
        st_preq = 1; st_pcnt = 4'd0; run(12);
        st_preq = 1; st_pcnt = 4'd1; run(10);
        cur_req = "R12 precedence"; push_frame(3, 0, 8'h77); run(2);
        st_preq = 1; st_pcnt = 4'd2; st_msg = 1; st_size = 3'd1; run(12);
        cur_req = "R2 drain"; run(6);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule